// File: doc/BRIEF.md
# DMA Channel Completion and Link Controller

This block keeps the per-channel control and status word of a multi-channel DMA engine. It also decides what happens when a channel's transfer loops end. The transfer engine reports four kinds of event, each tagged with a channel index: service start, minor loop done, major loop done (the iteration count has reached zero) and error. Software writes each channel's control word through a single write port and loads each channel's descriptor pointer through a second port.

A major-loop completion can trigger up to three actions in the same cycle:
- a one-cycle start pulse toward a linked channel, which also sets that channel's START bit;
- a clear of the channel's hardware request enable;
- a descriptor reload request that carries the channel's 32-byte aligned pointer.

While DONE is set, a software write cannot enable linking or scatter/gather. A misaligned pointer raises a per-channel configuration error and no reload request is issued. Registered outputs change one clock after the event that causes them.

Top module: `dma_link_ctrl`

## Requirements
- R1: A major-done event on a channel with link enable set gives `link_vld_o`=1 for one cycle on the next cycle, with `link_ch_o` equal to that channel's link field. On the same cycle the target channel's START bit reads 1. A channel may link to itself. A target index of N_CH or more raises the pulse but sets no START bit.
- R2: A major-done event on a channel with link enable clear gives no link pulse and sets no START bit.
- R3: A major-done event sets the channel's DONE flag. A service-start event clears DONE and START on that channel.
- R4: A service-start event sets ACTIVE. A minor-done, major-done or error event clears it.
- R5: A software write stores 0 in link enable and scatter/gather enable if the channel's DONE flag was 1 before the write.
- R6: A major-done event on a channel with scatter/gather enable set and pointer bits [4:0] equal to zero gives a one-cycle `sg_req_o` on the next cycle. That cycle also carries `sg_addr_o`, the pointer, and `cmpl_ch_o`, the channel.
- R7: When the same completion has a pointer with nonzero bits [4:0], it sets the channel's configuration-error bit and gives no `sg_req_o`.
- R8: A major-done event with the disable-request bit set clears the channel's ERQ bit and pulses `erq_clr_o` on the next cycle. With the bit clear, ERQ keeps its value and no pulse is issued.
- R9: With link, scatter/gather and disable-request all enabled, one major-done event produces all three actions on the same output cycle.
- R10: In the control word, DONE and the configuration-error bit can only be cleared by software. Writing 1 to either keeps its current value. ACTIVE cannot be written.
- R11: A software write to a channel that receives an engine event in the same cycle is discarded. A link start landing on a channel that software writes in the same cycle leaves START at 1.
- R12: The control word has these fields:

  | Bits | Field |
  |------|-------|
  | [5:0] | link channel |
  | [6] | link enable |
  | [7] | scatter/gather enable |
  | [8] | disable request |
  | [9] | DONE |
  | [10] | START |
  | [11] | ERQ |
  | [12] | ACTIVE |
  | [13] | configuration error |

  `rd_ctrl_o`/`rd_ptr_o` show the word and pointer of `rd_ch_i` combinationally. Everything resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_ch_i | input | CH_W | Channel of the engine event |
| evt_start_i | input | 1 | Service of the channel begins |
| evt_minor_i | input | 1 | Minor loop finished |
| evt_major_i | input | 1 | Iteration count reached zero |
| evt_err_i | input | 1 | Error on the channel |
| sw_we_i | input | 1 | Control word write strobe |
| sw_ch_i | input | CH_W | Channel written |
| sw_wdata_i | input | 14 | Control word write data |
| ptr_we_i | input | 1 | Pointer write strobe |
| ptr_ch_i | input | CH_W | Channel whose pointer is written |
| ptr_wdata_i | input | ADDR_W | Pointer write data |
| rd_ch_i | input | CH_W | Readback channel |
| rd_ctrl_o | output | 14 | Control word of rd_ch_i |
| rd_ptr_o | output | ADDR_W | Pointer of rd_ch_i |
| start_o | output | N_CH | START bit per channel |
| erq_o | output | N_CH | Hardware request enable per channel |
| active_o | output | N_CH | ACTIVE per channel |
| done_o | output | N_CH | DONE per channel |
| link_vld_o | output | 1 | Link start pulse |
| link_ch_o | output | 6 | Link target index |
| erq_clr_o | output | 1 | Request-enable clear pulse |
| sg_req_o | output | 1 | Descriptor reload request pulse |
| sg_addr_o | output | ADDR_W | Descriptor address |
| cmpl_ch_o | output | CH_W | Channel of the last major completion |

## Verification
A wrong per-channel bit shows up on the `done_o`, `active_o`, `start_o` or `erq_o` vectors one clock after the event that set it. A wrong enable bit stays hidden until that channel next completes its major loop, and then shows as a missing or extra pulse on the link, clear or reload outputs. Because the control word is read back every cycle, a wrong field is also visible on the cycle after it is written. That includes a write that should have been forced to zero or discarded.

// File: rtl/dma_lnk_pkg.sv
package dma_lnk_pkg;
  localparam int unsigned LINK_W = 6;
  localparam int unsigned CTRL_W = 14;
  localparam int unsigned ALIGN_W = 5;

  typedef struct packed {
    logic              cfg_err;
    logic              active;
    logic              erq;
    logic              start;
    logic              done;
    logic              dreq;
    logic              sg_en;
    logic              link_en;
    logic [LINK_W-1:0] link_ch;
  } ctrl_t;
endpackage

// File: rtl/dma_lnk_chan.sv
module dma_lnk_chan
  import dma_lnk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_hit_i,
  input  logic              evt_start_i,
  input  logic              evt_stop_i,
  input  logic              evt_major_i,
  input  logic              sw_hit_i,
  input  ctrl_t             sw_wdata_i,
  input  logic              link_hit_i,
  input  logic              ptr_we_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] ptr_o
);
  ctrl_t             q, nxt;
  logic [ADDR_W-1:0] ptr_q;
  logic              misalign;
  logic              unused_wr_active;

  assign unused_wr_active = sw_wdata_i.active;
  assign misalign = |ptr_q[ALIGN_W-1:0];

  always_comb begin
    nxt = q;
    // engine event owns the channel this cycle
    if (sw_hit_i && !evt_hit_i) begin
      nxt.link_ch = sw_wdata_i.link_ch;
      nxt.link_en = sw_wdata_i.link_en & ~q.done;
      nxt.sg_en   = sw_wdata_i.sg_en & ~q.done;
      nxt.dreq    = sw_wdata_i.dreq;
      nxt.done    = q.done & sw_wdata_i.done;
      nxt.start   = sw_wdata_i.start;
      nxt.erq     = sw_wdata_i.erq;
      nxt.cfg_err = q.cfg_err & sw_wdata_i.cfg_err;
    end
    if (evt_hit_i) begin
      if (evt_start_i) begin
        nxt.active = 1'b1;
        nxt.done   = 1'b0;
        nxt.start  = 1'b0;
      end
      if (evt_stop_i || evt_major_i) nxt.active = 1'b0;
      if (evt_major_i) begin
        nxt.done = 1'b1;
        if (q.dreq) nxt.erq = 1'b0;
        if (q.sg_en && misalign) nxt.cfg_err = 1'b1;
      end
    end
    if (link_hit_i) nxt.start = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= '0;
      ptr_q <= '0;
    end else begin
      q <= nxt;
      if (ptr_we_i) ptr_q <= ptr_wdata_i;
    end
  end

  assign ctrl_o = q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/dma_lnk_cmpl.sv
module dma_lnk_cmpl
  import dma_lnk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              major_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              link_en_i,
  input  logic [LINK_W-1:0] link_ch_i,
  input  logic              sg_en_i,
  input  logic              dreq_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              link_set_o,
  output logic [LINK_W-1:0] link_tgt_o,
  output logic              link_vld_o,
  output logic [LINK_W-1:0] link_ch_o,
  output logic              erq_clr_o,
  output logic              sg_req_o,
  output logic [ADDR_W-1:0] sg_addr_o,
  output logic [CH_W-1:0]   cmpl_ch_o
);
  logic aligned;

  assign aligned    = ~|ptr_i[ALIGN_W-1:0];
  assign link_set_o = major_i & link_en_i;
  assign link_tgt_o = link_ch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_vld_o <= 1'b0;
      link_ch_o  <= '0;
      erq_clr_o  <= 1'b0;
      sg_req_o   <= 1'b0;
      sg_addr_o  <= '0;
      cmpl_ch_o  <= '0;
    end else begin
      link_vld_o <= link_set_o;
      erq_clr_o  <= major_i & dreq_i;
      sg_req_o   <= major_i & sg_en_i & aligned;
      if (major_i) begin
        link_ch_o <= link_ch_i;
        sg_addr_o <= ptr_i;
        cmpl_ch_o <= ch_i;
      end
    end
  end
endmodule

// File: rtl/dma_link_ctrl.sv
module dma_link_ctrl
  import dma_lnk_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_W-1:0]   evt_ch_i,
  input  logic              evt_start_i,
  input  logic              evt_minor_i,
  input  logic              evt_major_i,
  input  logic              evt_err_i,
  input  logic              sw_we_i,
  input  logic [CH_W-1:0]   sw_ch_i,
  input  logic [13:0]       sw_wdata_i,
  input  logic              ptr_we_i,
  input  logic [CH_W-1:0]   ptr_ch_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [13:0]       rd_ctrl_o,
  output logic [ADDR_W-1:0] rd_ptr_o,
  output logic [N_CH-1:0]   start_o,
  output logic [N_CH-1:0]   erq_o,
  output logic [N_CH-1:0]   active_o,
  output logic [N_CH-1:0]   done_o,
  output logic              link_vld_o,
  output logic [5:0]        link_ch_o,
  output logic              erq_clr_o,
  output logic              sg_req_o,
  output logic [ADDR_W-1:0] sg_addr_o,
  output logic [CH_W-1:0]   cmpl_ch_o
);
  ctrl_t             ch_q  [N_CH];
  logic [ADDR_W-1:0] ptr_q [N_CH];
  ctrl_t             sel_c;
  logic [ADDR_W-1:0] sel_p;
  logic              any_evt;
  logic              link_set;
  logic [LINK_W-1:0] link_tgt;
  ctrl_t             wr_c;

  assign any_evt = evt_start_i | evt_minor_i | evt_major_i | evt_err_i;
  assign sel_c   = ch_q[evt_ch_i];
  assign sel_p   = ptr_q[evt_ch_i];
  assign wr_c    = ctrl_t'(sw_wdata_i);

  dma_lnk_cmpl #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_cmpl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .major_i    (evt_major_i),
    .ch_i       (evt_ch_i),
    .link_en_i  (sel_c.link_en),
    .link_ch_i  (sel_c.link_ch),
    .sg_en_i    (sel_c.sg_en),
    .dreq_i     (sel_c.dreq),
    .ptr_i      (sel_p),
    .link_set_o (link_set),
    .link_tgt_o (link_tgt),
    .link_vld_o (link_vld_o),
    .link_ch_o  (link_ch_o),
    .erq_clr_o  (erq_clr_o),
    .sg_req_o   (sg_req_o),
    .sg_addr_o  (sg_addr_o),
    .cmpl_ch_o  (cmpl_ch_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dma_lnk_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_hit_i   (any_evt && (evt_ch_i == CH_W'(g))),
      .evt_start_i (evt_start_i),
      .evt_stop_i  (evt_minor_i | evt_err_i),
      .evt_major_i (evt_major_i),
      .sw_hit_i    (sw_we_i && (sw_ch_i == CH_W'(g))),
      .sw_wdata_i  (wr_c),
      .link_hit_i  (link_set && (link_tgt == LINK_W'(g))),
      .ptr_we_i    (ptr_we_i && (ptr_ch_i == CH_W'(g))),
      .ptr_wdata_i (ptr_wdata_i),
      .ctrl_o      (ch_q[g]),
      .ptr_o       (ptr_q[g])
    );
    assign start_o[g]  = ch_q[g].start;
    assign erq_o[g]    = ch_q[g].erq;
    assign active_o[g] = ch_q[g].active;
    assign done_o[g]   = ch_q[g].done;
  end

  assign rd_ctrl_o = ch_q[rd_ch_i];
  assign rd_ptr_o  = ptr_q[rd_ch_i];
endmodule

// File: rtl/dma_link_ctrl_chk.sv
module dma_link_ctrl_chk #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [CH_W-1:0] evt_ch_i,
  input logic            evt_start_i,
  input logic            evt_major_i,
  input logic            evt_err_i,
  input logic [N_CH-1:0] start_o,
  input logic [N_CH-1:0] erq_o,
  input logic [N_CH-1:0] active_o,
  input logic [N_CH-1:0] done_o,
  input logic            link_vld_o,
  input logic [5:0]      link_ch_o,
  input logic            erq_clr_o,
  input logic            sg_req_o,
  input logic [4:0]      sg_addr_lo_i,
  input logic [CH_W-1:0] cmpl_ch_o
);
  a_r1_link_sets_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_vld_o && (32'(link_ch_o) < N_CH)) |-> start_o[link_ch_o[CH_W-1:0]]);

  a_r2_link_needs_major: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_vld_o |-> $past(evt_major_i));

  a_r3_major_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_major_i |=> done_o[$past(evt_ch_i)]);

  a_r3_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_start_i && !evt_major_i) |=> !done_o[$past(evt_ch_i)]);

  a_r4_err_drops_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_err_i && !evt_start_i) |=> !active_o[$past(evt_ch_i)]);

  a_r6_sg_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_req_o |-> (sg_addr_lo_i == 5'd0));

  a_r8_erq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erq_clr_o |-> !erq_o[cmpl_ch_o]);
endmodule

bind dma_link_ctrl dma_link_ctrl_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_ch_i     (evt_ch_i),
  .evt_start_i  (evt_start_i),
  .evt_major_i  (evt_major_i),
  .evt_err_i    (evt_err_i),
  .start_o      (start_o),
  .erq_o        (erq_o),
  .active_o     (active_o),
  .done_o       (done_o),
  .link_vld_o   (link_vld_o),
  .link_ch_o    (link_ch_o),
  .erq_clr_o    (erq_clr_o),
  .sg_req_o     (sg_req_o),
  .sg_addr_lo_i (sg_addr_o[4:0]),
  .cmpl_ch_o    (cmpl_ch_o)
);

// File: tb/dma_link_ctrl_bench.sv
module dma_link_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int CW = 3;
  localparam int AW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] evt_ch_i = '0;
  logic evt_start_i = 0, evt_minor_i = 0, evt_major_i = 0, evt_err_i = 0;
  logic sw_we_i = 0;
  logic [CW-1:0] sw_ch_i = '0;
  logic [13:0] sw_wdata_i = '0;
  logic ptr_we_i = 0;
  logic [CW-1:0] ptr_ch_i = '0;
  logic [AW-1:0] ptr_wdata_i = '0;
  logic [CW-1:0] rd_ch_i = '0;
  logic [13:0] rd_ctrl_o;
  logic [AW-1:0] rd_ptr_o, sg_addr_o;
  logic [N-1:0] start_o, erq_o, active_o, done_o;
  logic link_vld_o, erq_clr_o, sg_req_o;
  logic [5:0] link_ch_o;
  logic [CW-1:0] cmpl_ch_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [13:0] m_ctl [N];
  logic [AW-1:0] m_ptr [N];
  logic e_lv, e_ec, e_sg;
  logic [5:0] e_lch;
  logic [AW-1:0] e_addr;
  logic [CW-1:0] e_cch;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_link_ctrl u_dma_link_ctrl (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_apply();
    int c;
    logic any, mis;
    logic [13:0] o, n;
    c   = int'(evt_ch_i);
    any = evt_start_i | evt_minor_i | evt_major_i | evt_err_i;
    o   = m_ctl[c];
    mis = m_ptr[c][4:0] != 5'd0;
    e_lv = evt_major_i & o[6];
    e_ec = evt_major_i & o[8];
    e_sg = evt_major_i & o[7] & ~mis;
    if (evt_major_i) begin
      e_lch = o[5:0]; e_addr = m_ptr[c]; e_cch = evt_ch_i;
    end
    if (sw_we_i && !(any && sw_ch_i == evt_ch_i)) begin
      logic [13:0] s, d;
      s = m_ctl[sw_ch_i]; d = sw_wdata_i; n = s;
      n[5:0] = d[5:0];
      n[6] = d[6] & ~s[9];
      n[7] = d[7] & ~s[9];
      n[8] = d[8];
      n[9] = s[9] & d[9];
      n[10] = d[10];
      n[11] = d[11];
      n[13] = s[13] & d[13];
      m_ctl[sw_ch_i] = n;
    end
    if (any) begin
      n = m_ctl[c];
      if (evt_start_i) begin n[12] = 1; n[9] = 0; n[10] = 0; end
      if (evt_minor_i | evt_err_i | evt_major_i) n[12] = 0;
      if (evt_major_i) begin
        n[9] = 1;
        if (o[8]) n[11] = 0;
        if (o[7] && mis) n[13] = 1;
      end
      m_ctl[c] = n;
    end
    if (e_lv && int'(o[5:0]) < N) m_ctl[o[5:0]][10] = 1'b1;
    if (ptr_we_i) m_ptr[ptr_ch_i] = ptr_wdata_i;
  endtask

  task automatic idle();
    evt_start_i = 0; evt_minor_i = 0; evt_major_i = 0; evt_err_i = 0;
    sw_we_i = 0; ptr_we_i = 0;
  endtask

  // inputs are set after a falling edge; compare at the next falling edge
  task automatic step();
    logic [N-1:0] vs, ve, va, vd;
    model_apply();
    @(negedge clk_i);
    for (int i = 0; i < N; i++) begin
      vs[i] = m_ctl[i][10]; ve[i] = m_ctl[i][11];
      va[i] = m_ctl[i][12]; vd[i] = m_ctl[i][9];
    end
    chk("R1 start_o", 64'(start_o), 64'(vs));
    chk("R8 erq_o", 64'(erq_o), 64'(ve));
    chk("R4 active_o", 64'(active_o), 64'(va));
    chk("R3 done_o", 64'(done_o), 64'(vd));
    chk("R1 link_vld_o", 64'(link_vld_o), 64'(e_lv));
    chk("R1 link_ch_o", 64'(link_ch_o), 64'(e_lch));
    chk("R8 erq_clr_o", 64'(erq_clr_o), 64'(e_ec));
    chk("R6 sg_req_o", 64'(sg_req_o), 64'(e_sg));
    chk("R6 sg_addr_o", 64'(sg_addr_o), 64'(e_addr));
    chk("R6 cmpl_ch_o", 64'(cmpl_ch_o), 64'(e_cch));
    chk("R12 rd_ctrl_o", 64'(rd_ctrl_o), 64'(m_ctl[rd_ch_i]));
    chk("R12 rd_ptr_o", 64'(rd_ptr_o), 64'(m_ptr[rd_ch_i]));
    idle();
  endtask

  task automatic sw_wr(int ch, logic [13:0] d);
    sw_we_i = 1; sw_ch_i = CW'(ch); sw_wdata_i = d; rd_ch_i = CW'(ch);
    step();
  endtask

  task automatic ptr_wr(int ch, logic [AW-1:0] p);
    ptr_we_i = 1; ptr_ch_i = CW'(ch); ptr_wdata_i = p; rd_ch_i = CW'(ch);
    step();
  endtask

  task automatic major(int ch);
    evt_major_i = 1; evt_ch_i = CW'(ch); rd_ch_i = CW'(ch);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_ctl[i] = '0; m_ptr[i] = '0; end
    e_lv = 0; e_ec = 0; e_sg = 0; e_lch = '0; e_addr = '0; e_cch = '0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 reset rd_ctrl_o", 64'(rd_ctrl_o), 64'd0);
    chk("R12 reset vectors", 64'({start_o, erq_o, active_o, done_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5: enables forced to zero while DONE is set
    sw_wr(2, 14'h0000);
    major(2);
    sw_wr(2, 14'b00_0010_1100_0011 | 14'h0200);
    chk("R5 link_en/sg_en forced", 64'(rd_ctrl_o[7:6]), 64'd0);
    chk("R5 done kept", 64'(rd_ctrl_o[9]), 64'd1);

    // R10: writing 0 clears DONE, writing 1 does not set it, ACTIVE not writable
    sw_wr(2, 14'h1000);
    chk("R10 done cleared", 64'(rd_ctrl_o[9]), 64'd0);
    chk("R10 active not written", 64'(rd_ctrl_o[12]), 64'd0);
    sw_wr(2, 14'h0200);
    chk("R10 done not set by write", 64'(rd_ctrl_o[9]), 64'd0);

    // R9: all three actions from one completion
    ptr_wr(3, 32'h0000_0100);
    sw_wr(3, 14'h0800 | 14'h0100 | 14'h0080 | 14'h0040 | 14'd5);
    major(3);
    chk("R9 link pulse", 64'({link_vld_o, link_ch_o}), 64'({1'b1, 6'd5}));
    chk("R9 target start", 64'(start_o[5]), 64'd1);
    chk("R9 sg req", 64'({sg_req_o, sg_addr_o}), 64'({1'b1, 32'h100}));
    chk("R9 erq clear", 64'({erq_clr_o, erq_o[3]}), 64'({1'b1, 1'b0}));
    step();
    chk("R1 pulse single cycle", 64'(link_vld_o), 64'd0);

    // R7: misaligned pointer
    ptr_wr(4, 32'h0000_0104);
    sw_wr(4, 14'h0080);
    major(4);
    chk("R7 no sg req", 64'(sg_req_o), 64'd0);
    chk("R7 cfg_err set", 64'(rd_ctrl_o[13]), 64'd1);

    // R1: self link
    sw_wr(1, 14'h0040 | 14'd1);
    major(1);
    chk("R1 self link start", 64'({link_vld_o, start_o[1]}), 64'({1'b1, 1'b1}));

    // R2 and R8: no link, request enable kept
    sw_wr(0, 14'h0800 | 14'd6);
    major(0);
    chk("R2 no link pulse", 64'(link_vld_o), 64'd0);
    chk("R2 no target start", 64'(start_o[6]), 64'd0);
    chk("R8 erq kept", 64'({erq_clr_o, erq_o[0]}), 64'({1'b0, 1'b1}));

    // R11: event and write on the same channel
    evt_start_i = 1; evt_ch_i = 3'd6; sw_we_i = 1; sw_ch_i = 3'd6;
    sw_wdata_i = 14'd7; rd_ch_i = 3'd6;
    step();
    chk("R11 write discarded", 64'(rd_ctrl_o[5:0]), 64'd0);
    chk("R4 active on start", 64'(active_o[6]), 64'd1);
    // R11: link start beats write of START=0 on target
    sw_wr(1, 14'h0040 | 14'd2);
    sw_wr(1, 14'h0040 | 14'd2);
    evt_major_i = 1; evt_ch_i = 3'd1; sw_we_i = 1; sw_ch_i = 3'd2;
    sw_wdata_i = 14'h0000; rd_ch_i = 3'd2;
    step();
    chk("R11 link start wins", 64'(start_o[2]), 64'd1);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int t;
      t = int'($urandom_range(0, 5));
      evt_ch_i = CW'($urandom);
      case (t)
        1: evt_start_i = 1;
        2: evt_minor_i = 1;
        3, 4: evt_major_i = 1;
        5: evt_err_i = 1;
        default: ;
      endcase
      if ($urandom_range(0, 9) < 3) begin
        sw_we_i = 1; sw_ch_i = CW'($urandom);
        sw_wdata_i = 14'($urandom);
        if ($urandom_range(0, 1) == 1) sw_wdata_i[5:3] = 3'd0;
      end
      if ($urandom_range(0, 9) < 2) begin
        ptr_we_i = 1; ptr_ch_i = CW'($urandom);
        ptr_wdata_i = $urandom;
        if ($urandom_range(0, 1) == 1) ptr_wdata_i[4:0] = 5'd0;
      end
      rd_ch_i = CW'($urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule